// File: doc/BRIEF.md
# Timer capture/compare channel

This block is one channel of a small free-running timer. It holds its own counter, which runs only while a start input is high. The counter either counts up and wraps, or counts from zero to all-ones and back down again, with a direction flag that tells which way it is heading. The channel works in one of two roles. In capture role it brings an asynchronous input into the clock domain and latches the counter value on a chosen edge of that input. In compare role it drives an output pin from a 3-bit action code, using a compare value that is double-buffered.

Software writes new compare values into a holding register. The working copy only takes them over while the counter sits at zero, so that a period never sees a half-updated threshold. A single event flag per channel collects capture and compare events. It is cleared by a write-one pulse, and an enable gates it onto an interrupt line. Register decoding, pin multiplexing and interrupt vectoring live outside the block.

Top module: `tmr_cc_chan`

## Requirements
- R1: With `updown_i` low, the counter adds one per clock while `start_i` is high and wraps from all-ones to zero. It holds while `start_i` is low. A `clr_i` pulse returns it to zero, with priority over counting.
- R2: With `updown_i` high, the counter runs 0, 1, ..., all-ones, all-ones minus one, ..., 0, 1, ... and so on. `dir_down_o` is 1 from the clock the count reaches all-ones until the clock it returns to zero, and is 0 otherwise.
- R3: The capture pin passes through SYNC_STAGES flops and one more edge register. `cap_val_o` takes the count that is present in the clock where the synchronized level first differs from the edge register.
- R4: `edge_sel_i` selects the capture edge: 00 none, 01 rising, 10 falling, 11 both. With 00, neither `cap_val_o` nor the flag changes.
- R5: Captures happen only while `cmp_sel_i` is 0. With `cmp_sel_i` 1, pin activity changes neither `cap_val_o` nor the flag. Compare actions happen only while `cmp_sel_i` is 1.
- R6: A match is the counter holding the working compare value in the clock after a counting step. Action 000 drives the pin to 1 on a match, 001 drives it to 0, and 010 inverts it.
- R7: With `updown_i` high, action 011 drives the pin to 1 on a match while `dir_down_o` is 0 and to 0 on a match while it is 1. Action 100 does the reverse. With `updown_i` low, 011 sets on a match and clears when a step lands on zero, and 100 does the reverse. A match wins over the zero rule.
- R8: Action 101 sets the pin on a match and clears it when a step lands on all-ones. Action 110 clears it on a match and sets it when a step lands on zero. A match wins over the other rule.
- R9: `cmp_wr_i` loads a holding register. The working compare value copies the holding register at each clock where the count is zero, and at no other time.
- R10: A `clr_i` pulse, or a `mode_wr_i` with code 111, forces the pin to the start level of the stored action: 1 for 001, 100 and 110, and 0 otherwise. Code 111 leaves the stored action unchanged. A write of any other code stores it, and that clock takes no pin action.
- R11: A capture or a match sets `flag_o`. A `flag_clr_i` pulse clears it, unless an event occurs in the same clock, in which case the flag stays set. `irq_o` is `flag_o` AND `irq_en_i`.
- R12: The pin changes at most once per clock, and only in a clock that follows a compare event, a clear or a 111 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Counter runs while high |
| updown_i | input | 1 | 1 selects up/down counting, 0 up-only |
| clr_i | input | 1 | Counter clear and pin re-initialise pulse |
| cmp_sel_i | input | 1 | 1 compare role, 0 capture role |
| edge_sel_i | input | 2 | Capture edge select |
| cap_pin_i | input | 1 | Asynchronous capture input |
| mode_wr_i | input | 1 | Write strobe for the action code |
| mode_i | input | 3 | Action code written on `mode_wr_i` |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_data_i | input | W | Compare value written on `cmp_wr_i` |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| count_o | output | W | Current counter value |
| dir_down_o | output | 1 | Counting-down indicator |
| cap_val_o | output | W | Last captured count |
| cmp_pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A wrong counter or direction state shows on `count_o` and `dir_down_o` at the next clock. It also shifts every later match, so pin and flag errors follow within one count period. A corrupted working compare value, or a reload outside the zero count, shows as a pin edge and a flag rise at the wrong count, at the latest one full period (510 clocks in up/down counting) after the fault. A bad synchronizer or edge register shows as a captured count that is off by one or more, or as a missing or extra flag rise, two to three clocks after the pin moves.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

   typedef enum logic [2:0] {
      ACT_SET      = 3'd0,
      ACT_CLR      = 3'd1,
      ACT_TGL      = 3'd2,
      ACT_SET_UP   = 3'd3,
      ACT_CLR_UP   = 3'd4,
      ACT_SET_TOP  = 3'd5,
      ACT_CLR_ZERO = 3'd6,
      ACT_INIT     = 3'd7
   } cmp_act_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   // Start level of the pin for each stored action code
   function automatic logic start_level(cmp_act_e a);
      return (a == ACT_CLR) || (a == ACT_CLR_UP) || (a == ACT_CLR_ZERO);
   endfunction

endpackage

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         updown_i,
   input  logic         clr_i,
   output logic [W-1:0] count_o,
   output logic         dir_down_o,
   output logic         stepped_o
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;
   logic         dir_q;
   logic         step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         step_q <= 1'b0;
      end else begin
         step_q <= run_i & ~clr_i;
         if (clr_i) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
         end else if (run_i) begin
            if (!updown_i) begin
               cnt_q <= cnt_q + ONE;
               dir_q <= 1'b0;
            end else if (!dir_q) begin
               cnt_q <= cnt_q + ONE;
               if (cnt_q == MAXV - ONE) dir_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
               if (cnt_q == ONE) dir_q <= 1'b0;
            end
         end
      end
   end

   assign count_o    = cnt_q;
   assign dir_down_o = dir_q;
   assign stepped_o  = step_q;

   // R1
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && !updown_i) |=> (cnt_q == ($past(cnt_q) + ONE)));

   // R1
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(cnt_q));

   // R2
   turn_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && updown_i && !clr_i && !dir_q && cnt_q == MAXV - ONE) |=> (dir_q && cnt_q == MAXV));

   // R2
   stay_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && updown_i && !clr_i && dir_q && cnt_q != ONE) |=> dir_q);

endmodule

// File: rtl/tmr_cc_capture.sv
module tmr_cc_capture #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_i,
   input  logic [1:0]   edge_sel_i,
   input  logic         pin_i,
   input  logic [W-1:0] count_i,
   output logic [W-1:0] cap_val_o,
   output logic         cap_evt_o
);
   import tmr_cc_pkg::*;

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [W-1:0]           cap_q;
   logic                   rise, fall, evt;
   edge_sel_e              esel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= pin_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign esel = edge_sel_e'(edge_sel_i);
   assign rise = sync_q[LAST] & ~prev_q;
   assign fall = ~sync_q[LAST] & prev_q;

   always_comb begin
      unique case (esel)
         EDGE_RISE: evt = rise;
         EDGE_FALL: evt = fall;
         EDGE_BOTH: evt = rise | fall;
         default:   evt = 1'b0;
      endcase
      evt = evt & active_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_q <= '0;
      else if (evt) cap_q <= count_i;
   end

   assign cap_val_o = cap_q;
   assign cap_evt_o = evt;

   // R4
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(cap_q));

   // R5
   cap_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |-> !evt);

endmodule

// File: rtl/tmr_cc_compare.sv
module tmr_cc_compare #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_i,
   input  logic         updown_i,
   input  logic [W-1:0] count_i,
   input  logic         dir_down_i,
   input  logic         stepped_i,
   input  logic         clr_i,
   input  logic         mode_wr_i,
   input  logic [2:0]   mode_i,
   input  logic         shd_wr_i,
   input  logic [W-1:0] shd_data_i,
   output logic         pin_o,
   output logic         match_o
);
   import tmr_cc_pkg::*;

   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic [W-1:0] shadow_q, working_q;
   cmp_act_e     act_q;
   logic         pin_q, pin_d;
   logic         match, at_zero, at_top, force_init, store_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q  <= '0;
         working_q <= '0;
      end else begin
         if (shd_wr_i)        shadow_q  <= shd_data_i;
         if (count_i == '0)   working_q <= shadow_q;
      end
   end

   assign match      = active_i & stepped_i & (count_i == working_q);
   assign at_zero    = active_i & stepped_i & (count_i == '0);
   assign at_top     = active_i & stepped_i & (count_i == MAXV);
   assign force_init = clr_i | (mode_wr_i & (mode_i == 3'b111));
   assign store_mode = mode_wr_i & (mode_i != 3'b111);

   always_comb begin
      pin_d = pin_q;
      if (force_init) begin
         pin_d = start_level(act_q);
      end else if (!store_mode) begin
         unique case (act_q)
            ACT_SET: if (match) pin_d = 1'b1;
            ACT_CLR: if (match) pin_d = 1'b0;
            ACT_TGL: if (match) pin_d = ~pin_q;
            ACT_SET_UP: begin
               if (updown_i)     begin if (match) pin_d = ~dir_down_i; end
               else if (match)   pin_d = 1'b1;
               else if (at_zero) pin_d = 1'b0;
            end
            ACT_CLR_UP: begin
               if (updown_i)     begin if (match) pin_d = dir_down_i; end
               else if (match)   pin_d = 1'b0;
               else if (at_zero) pin_d = 1'b1;
            end
            ACT_SET_TOP: begin
               if (match)       pin_d = 1'b1;
               else if (at_top) pin_d = 1'b0;
            end
            ACT_CLR_ZERO: begin
               if (match)        pin_d = 1'b0;
               else if (at_zero) pin_d = 1'b1;
            end
            default: pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= ACT_SET;
         pin_q <= 1'b0;
      end else begin
         pin_q <= pin_d;
         if (store_mode) act_q <= cmp_act_e'(mode_i);
      end
   end

   assign pin_o   = pin_q;
   assign match_o = match;

   // R9
   reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (working_q != $past(working_q)) |-> ($past(count_i) == '0));

   // R12
   pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_q != $past(pin_q)) |-> $past(match | at_zero | at_top | force_init));

   // R10
   init_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pin_q == start_level($past(act_q))));

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         updown_i,
   input  logic         clr_i,
   input  logic         cmp_sel_i,
   input  logic [1:0]   edge_sel_i,
   input  logic         cap_pin_i,
   input  logic         mode_wr_i,
   input  logic [2:0]   mode_i,
   input  logic         cmp_wr_i,
   input  logic [W-1:0] cmp_data_i,
   input  logic         irq_en_i,
   input  logic         flag_clr_i,
   output logic [W-1:0] count_o,
   output logic         dir_down_o,
   output logic [W-1:0] cap_val_o,
   output logic         cmp_pin_o,
   output logic         flag_o,
   output logic         irq_o
);

   if (W < 2 || W > 16) begin : g_width_bad
      $error("tmr_cc_chan: W must lie in 2..16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_sync_bad
      $error("tmr_cc_chan: SYNC_STAGES must lie in 2..4");
   end

   logic [W-1:0] cnt;
   logic         dir_dn, stepped, cap_evt, match, flag_q, evt;

   tmr_cc_counter #(.W(W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (start_i),
      .updown_i   (updown_i),
      .clr_i      (clr_i),
      .count_o    (cnt),
      .dir_down_o (dir_dn),
      .stepped_o  (stepped)
   );

   tmr_cc_capture #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (~cmp_sel_i),
      .edge_sel_i (edge_sel_i),
      .pin_i      (cap_pin_i),
      .count_i    (cnt),
      .cap_val_o  (cap_val_o),
      .cap_evt_o  (cap_evt)
   );

   tmr_cc_compare #(.W(W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (cmp_sel_i),
      .updown_i   (updown_i),
      .count_i    (cnt),
      .dir_down_i (dir_dn),
      .stepped_i  (stepped),
      .clr_i      (clr_i),
      .mode_wr_i  (mode_wr_i),
      .mode_i     (mode_i),
      .shd_wr_i   (cmp_wr_i),
      .shd_data_i (cmp_data_i),
      .pin_o      (cmp_pin_o),
      .match_o    (match)
   );

   assign evt = cap_evt | match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (evt)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign count_o    = cnt;
   assign dir_down_o = dir_dn;
   assign flag_o     = flag_q;
   assign irq_o      = flag_q & irq_en_i;

   // R11
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_o);

   // R11
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !evt) |=> !flag_o);

   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en_i && flag_o));

endmodule

// File: tb/tb_tmr_cc_chan.sv
module tb_tmr_cc_chan;

   localparam int W = 8;
   localparam logic [W-1:0] MAXV = 8'hFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 0, updown_i = 0, clr_i = 0, cmp_sel_i = 0;
   logic [1:0]   edge_sel_i = 0;
   logic         cap_pin_i = 0, mode_wr_i = 0;
   logic [2:0]   mode_i = 0;
   logic         cmp_wr_i = 0;
   logic [W-1:0] cmp_data_i = 0;
   logic         irq_en_i = 0, flag_clr_i = 0;
   logic [W-1:0] count_o, cap_val_o;
   logic         dir_down_o, cmp_pin_o, flag_o, irq_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tmr_cc_chan #(.W(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .updown_i(updown_i),
      .clr_i(clr_i), .cmp_sel_i(cmp_sel_i), .edge_sel_i(edge_sel_i),
      .cap_pin_i(cap_pin_i), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
      .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i), .irq_en_i(irq_en_i),
      .flag_clr_i(flag_clr_i), .count_o(count_o), .dir_down_o(dir_down_o),
      .cap_val_o(cap_val_o), .cmp_pin_o(cmp_pin_o), .flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Reference model built from the requirements
   logic [W-1:0] m_cnt, m_cap, m_shd, m_act;
   logic         m_dir, m_step, m_out, m_flag, m_prev;
   logic [1:0]   m_sync;
   logic [2:0]   m_mode;

   function automatic logic lvl(input logic [2:0] m);
      return (m == 3'd1) || (m == 3'd4) || (m == 3'd6);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_cap = 0; m_shd = 0; m_act = 0; m_dir = 0; m_step = 0;
         m_out = 0; m_flag = 0; m_prev = 0; m_sync = 0; m_mode = 0;
      end else begin
         logic ecap, mt, zr, tp, o, nd;
         logic [W-1:0] nc;
         ecap = !cmp_sel_i && ((edge_sel_i[0] && m_sync[1] && !m_prev) ||
                               (edge_sel_i[1] && !m_sync[1] && m_prev));
         mt = cmp_sel_i && m_step && (m_cnt == m_act);
         zr = cmp_sel_i && m_step && (m_cnt == 0);
         tp = cmp_sel_i && m_step && (m_cnt == MAXV);
         o = m_out;
         if (clr_i || (mode_wr_i && mode_i == 3'd7)) o = lvl(m_mode);
         else if (!mode_wr_i) begin
            case (m_mode)
               3'd0: if (mt) o = 1;
               3'd1: if (mt) o = 0;
               3'd2: if (mt) o = !o;
               3'd3: if (updown_i) begin if (mt) o = !m_dir; end
                     else if (mt) o = 1; else if (zr) o = 0;
               3'd4: if (updown_i) begin if (mt) o = m_dir; end
                     else if (mt) o = 0; else if (zr) o = 1;
               3'd5: if (mt) o = 1; else if (tp) o = 0;
               3'd6: if (mt) o = 0; else if (zr) o = 1;
               default: ;
            endcase
         end
         nc = m_cnt; nd = m_dir;
         if (clr_i) begin nc = 0; nd = 0; end
         else if (start_i) begin
            if (!updown_i) begin nc = m_cnt + 1; nd = 0; end
            else if (!m_dir) begin nc = m_cnt + 1; if (m_cnt == MAXV - 1) nd = 1; end
            else begin nc = m_cnt - 1; if (m_cnt == 1) nd = 0; end
         end
         if (ecap || mt) m_flag = 1; else if (flag_clr_i) m_flag = 0;
         if (ecap) m_cap = m_cnt;
         if (m_cnt == 0) m_act = m_shd;
         if (cmp_wr_i) m_shd = cmp_data_i;
         if (mode_wr_i && mode_i != 3'd7) m_mode = mode_i;
         m_out = o;
         m_step = start_i && !clr_i;
         m_cnt = nc; m_dir = nd;
         m_prev = m_sync[1];
         m_sync = {m_sync[0], cap_pin_i};
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 count", count_o, m_cnt);
         chk("R2 dir_down", dir_down_o, m_dir);
         chk("R3 cap_val", cap_val_o, m_cap);
         chk(m_mode <= 2 ? "R6 pin" : (m_mode <= 4 ? "R7 pin" : "R8 pin"), cmp_pin_o, m_out);
         chk("R11 flag", flag_o, m_flag);
         chk("R11 irq", irq_o, m_flag & irq_en_i);
      end
   end

   task automatic finish_up;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_clr;
      @(negedge clk) clr_i = 1;
      @(negedge clk) clr_i = 0;
   endtask

   task automatic wr_mode(input logic [2:0] m);
      @(negedge clk) begin mode_wr_i = 1; mode_i = m; end
      @(negedge clk) mode_wr_i = 0;
   endtask

   task automatic wr_cmp(input logic [W-1:0] v);
      @(negedge clk) begin cmp_wr_i = 1; cmp_data_i = v; end
      @(negedge clk) cmp_wr_i = 0;
   endtask

   task automatic wait_count(input logic [W-1:0] v);
      do @(negedge clk); while (count_o !== v);
   endtask

   initial begin
      logic [W-1:0] cvals [4];
      logic [W-1:0] held;
      int changes;
      logic last;
      cvals[0] = 8'd0; cvals[1] = 8'd5; cvals[2] = 8'd128; cvals[3] = 8'd255;

      tick(3);
      // Reset state
      chk("R1 reset count", count_o, 0);
      chk("R10 reset pin", cmp_pin_o, 0);
      chk("R11 reset flag", flag_o, 0);
      chk("R2 reset dir", dir_down_o, 0);
      rst_n = 1;
      tick(2);

      // Compare sweep over both counting modes, all actions, several values
      cmp_sel_i = 1;
      for (int ud = 0; ud < 2; ud++) begin
         for (int m = 0; m < 7; m++) begin
            for (int c = 0; c < 4; c++) begin
               @(negedge clk) begin start_i = 0; updown_i = ud[0]; irq_en_i = ud[0] ^ m[0]; end
               wr_mode(m[2:0]);
               wr_cmp(cvals[c]);
               do_clr();
               tick(1);
               start_i = 1;
               for (int i = 0; i < 530; i++) begin
                  @(negedge clk);
                  flag_clr_i = (i % 37 == 0);
                  start_i = !(i % 97 == 50);
                  if (i == 300) begin mode_wr_i = 1; mode_i = 3'd7; end
                  else mode_wr_i = 0;
                  if (i == 400) begin cmp_wr_i = 1; cmp_data_i = cvals[c] + 8'd3; end
                  else cmp_wr_i = 0;
               end
               @(negedge clk) begin flag_clr_i = 0; mode_wr_i = 0; cmp_wr_i = 0; end
            end
         end
      end

      // R9: a new compare value waits for the zero count
      @(negedge clk) begin start_i = 0; updown_i = 0; end
      wr_mode(3'd0);
      wr_cmp(8'd200);
      do_clr();
      tick(2);
      start_i = 1;
      wait_count(8'd50);
      wr_cmp(8'd100);
      wait_count(8'd150);
      chk("R9 pin before old value", cmp_pin_o, 0);
      wait_count(8'd210);
      chk("R9 pin after old value", cmp_pin_o, 1);

      // R10: 111 forces the start level and keeps the action
      wr_mode(3'd1);
      @(negedge clk) start_i = 0;
      wr_mode(3'd7);
      chk("R10 force level for 001", cmp_pin_o, 1);
      wr_mode(3'd0);
      do_clr();
      chk("R10 clear level for 000", cmp_pin_o, 0);
      wr_mode(3'd6);
      do_clr();
      chk("R10 clear level for 110", cmp_pin_o, 1);

      // R12: toggle action changes the pin once per period
      wr_mode(3'd2);
      wr_cmp(8'd77);
      do_clr();
      tick(2);
      start_i = 1;
      changes = 0;
      last = cmp_pin_o;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (cmp_pin_o !== last) changes++;
         last = cmp_pin_o;
      end
      chk("R12 pin changes per period", changes, 1);

      // R5: pin activity ignored in compare role
      @(negedge clk) begin start_i = 0; edge_sel_i = 2'b11; flag_clr_i = 1; end
      @(negedge clk) flag_clr_i = 0;
      held = cap_val_o;
      for (int i = 0; i < 6; i++) @(negedge clk) cap_pin_i = ~cap_pin_i;
      tick(4);
      chk("R5 cap_val untouched", cap_val_o, held);
      chk("R5 flag untouched", flag_o, 0);

      // Capture sweep over edge selections and counting modes
      cmp_sel_i = 0;
      for (int es = 0; es < 4; es++) begin
         for (int ud = 0; ud < 2; ud++) begin
            @(negedge clk) begin edge_sel_i = es[1:0]; updown_i = ud[0]; end
            do_clr();
            start_i = 1;
            for (int i = 0; i < 320; i++) begin
               @(negedge clk);
               if (i % (7 + es) == 0) cap_pin_i = ~cap_pin_i;
               flag_clr_i = (i % 29 == 3);
            end
            @(negedge clk) flag_clr_i = 0;
         end
      end

      // R3: frozen counter gives an exact capture value
      @(negedge clk) begin start_i = 0; edge_sel_i = 2'b01; cap_pin_i = 0; end
      do_clr();
      start_i = 1;
      wait_count(8'd42);
      start_i = 0;
      tick(4);
      @(negedge clk) cap_pin_i = 1;
      tick(4);
      chk("R3 captured frozen count", cap_val_o, 42);

      // R4: edge selection 00 captures nothing
      @(negedge clk) begin edge_sel_i = 2'b00; flag_clr_i = 1; start_i = 1; end
      @(negedge clk) flag_clr_i = 0;
      held = cap_val_o;
      for (int i = 0; i < 8; i++) @(negedge clk) cap_pin_i = ~cap_pin_i;
      tick(4);
      chk("R4 no capture on 00", cap_val_o, held);
      chk("R4 no flag on 00", flag_o, 0);

      // R11: clear and event in the same clock keeps the flag
      @(negedge clk) begin edge_sel_i = 2'b11; cap_pin_i = ~cap_pin_i; end
      tick(1);
      @(negedge clk) flag_clr_i = 1;
      @(negedge clk) flag_clr_i = 0;
      chk("R11 event beats clear", flag_o, 1);

      tick(4);
      finish_up();
   end

endmodule